// File: doc/BRIEF.md
# Page Write Buffer with Self-Timed Commit

This block sits between the byte-level slave controller of a serial memory and its 256-byte storage array. The controller reports each bus event as a one-cycle pulse: a START, the received word-address byte, each received data byte, and a STOP. The word address sets a fixed page base and a starting offset. The data bytes that follow collect in an eight-entry page latch, and the offset steps modulo eight. Nothing reaches the array while the bytes arrive.

On STOP, the entries that received a byte are written to the array through a single write port, one per cycle in ascending offset order. A busy flag then stays high for a fixed number of clock cycles that models the self-timed write cycle. While busy is high, the controller withholds acknowledges and the block ignores every bus event. A write-protect input held high at STOP discards the collected page without writing anything and without raising busy.

The controller is a three-state machine. IDLE waits for a word address. COLLECT fills the latch. PROGRAM drains the latch and runs the timer. The transitions are:
- IDLE to COLLECT on an address byte, which also loads the base and offset and clears the latch.
- COLLECT to IDLE on a repeated START, which clears the latch.
- COLLECT to IDLE on a STOP that has no data or has write-protect high, which clears the latch.
- COLLECT to PROGRAM on a STOP with data and write-protect low.
- PROGRAM to IDLE when the timer expires, which clears the latch.

Top module: `page_write_buffer`

## Requirements
- R1: The address byte's upper five bits are the page base for the whole transaction, and its low three bits are the start offset. Data byte k, counted from 0, lands at array address {base, (offset + k) mod 8}.
- R2: When more than eight data bytes arrive before STOP, the offset wraps within the page. A later byte at the same offset replaces the earlier one, and only the newest value is written.
- R3: No array write happens before STOP. Every write occurs while busy is high.
- R4: Only offsets that received a byte in the transaction are written, each exactly once and in ascending offset order. A single-byte transaction writes exactly one location.
- R5: After a STOP that follows at least one data byte with write-protect low, busy is high from the next cycle for exactly WR_CYCLES cycles. All writes fall inside that window.
- R6: When write-protect is high at STOP, no array write takes place and busy stays low. Data bytes are still accepted and then discarded.
- R7: A STOP that follows only an address byte, with no data, raises no busy and writes nothing.
- R8: A START clears the latch and the offset. Bytes received before a repeated START are never written.
- R9: While busy is high, START, address, data and STOP events are all ignored. They leave no write and no second busy window behind them.
- R10: After reset, busy is low and no write is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle pulse: START seen on the bus |
| stop_i | input | 1 | One-cycle pulse: STOP seen on the bus |
| waddr_vld_i | input | 1 | One-cycle pulse: byte_i holds the word address |
| wdata_vld_i | input | 1 | One-cycle pulse: byte_i holds a data byte |
| byte_i | input | DATA_W | Received byte |
| wp_i | input | 1 | Write protect, high blocks commits |
| busy_o | output | 1 | Self-timed write cycle in progress |
| arr_we_o | output | 1 | Array write enable |
| arr_addr_o | output | ADDR_W | Array write address |
| arr_data_o | output | DATA_W | Array write data |

## Verification
The hardest situation to reach is a page whose latch holds a stale entry next to fresh ones. This happens when more than eight bytes wrap the offset over a start offset other than zero. It also happens when a repeated START abandons half-collected bytes before a new address. The bench sweeps every start offset against byte counts from one to ten, and computes the surviving value at each offset arithmetically. It also injects a complete transaction while busy is high, to show that the PROGRAM state lets nothing through.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
    typedef enum logic [1:0] {
        PW_IDLE    = 2'd0,
        PW_COLLECT = 2'd1,
        PW_PROGRAM = 2'd2
    } pw_state_t;
endpackage

// File: rtl/pwb_page_latch.sv
module pwb_page_latch #(
    parameter int DATA_W  = 8,
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              wr_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_valid_o,
    output logic              any_valid_o
);
    logic [DATA_W-1:0] data_q [ENTRIES];
    logic [ENTRIES-1:0] valid_q;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n || clr_i) begin
                valid_q[e] <= 1'b0;
            end else if (wr_i && wr_idx_i == IDX_W'(e)) begin
                valid_q[e] <= 1'b1;
            end
        end
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_q[e] <= '0;
            end else if (wr_i && wr_idx_i == IDX_W'(e)) begin
                data_q[e] <= wr_data_i;
            end
        end
    end

    assign rd_data_o   = data_q[rd_idx_i];
    assign rd_valid_o  = valid_q[rd_idx_i];
    assign any_valid_o = |valid_q;

    // R8: a clear leaves the latch empty on the next cycle
    p_clr_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !any_valid_o);
endmodule

// File: rtl/pwb_cycle_timer.sv
module pwb_cycle_timer #(
    parameter int CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic run_i,
    output logic done_o
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || load_i) begin
            cnt_q <= '0;
        end else if (run_i && !done_o) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign done_o = run_i && (cnt_q == CNT_W'(CYCLES - 1));

    // R5: the count never passes the programmed window
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(CYCLES));
endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer
    import pwb_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int DATA_W       = 8,
    parameter int PAGE_ENTRIES = 8,
    parameter int WR_CYCLES    = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              waddr_vld_i,
    input  logic              wdata_vld_i,
    input  logic [DATA_W-1:0] byte_i,
    input  logic              wp_i,
    output logic              busy_o,
    output logic              arr_we_o,
    output logic [ADDR_W-1:0] arr_addr_o,
    output logic [DATA_W-1:0] arr_data_o
);
    localparam int OFF_W  = $clog2(PAGE_ENTRIES);
    localparam int BASE_W = ADDR_W - OFF_W;
    localparam int SCAN_W = OFF_W + 1;

    pw_state_t         state_q, state_d;
    logic [OFF_W-1:0]  off_q;
    logic [BASE_W-1:0] base_q;
    logic [SCAN_W-1:0] scan_q;

    logic latch_clr, latch_wr, addr_load, tmr_load, tmr_done;
    logic rd_valid, any_valid;
    logic [DATA_W-1:0] rd_data;

    pwb_page_latch #(
        .DATA_W  (DATA_W),
        .ENTRIES (PAGE_ENTRIES),
        .IDX_W   (OFF_W)
    ) u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (latch_clr),
        .wr_i        (latch_wr),
        .wr_idx_i    (off_q),
        .wr_data_i   (byte_i),
        .rd_idx_i    (scan_q[OFF_W-1:0]),
        .rd_data_o   (rd_data),
        .rd_valid_o  (rd_valid),
        .any_valid_o (any_valid)
    );

    pwb_cycle_timer #(
        .CYCLES (WR_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .run_i  (state_q == PW_PROGRAM),
        .done_o (tmr_done)
    );

    // next state and control strobes
    always_comb begin
        state_d   = state_q;
        latch_clr = 1'b0;
        latch_wr  = 1'b0;
        addr_load = 1'b0;
        tmr_load  = 1'b0;
        unique case (state_q)
            PW_IDLE: begin
                if (start_i) begin
                    latch_clr = 1'b1;
                end else if (waddr_vld_i) begin
                    latch_clr = 1'b1;
                    addr_load = 1'b1;
                    state_d   = PW_COLLECT;
                end
            end
            PW_COLLECT: begin
                if (start_i) begin
                    latch_clr = 1'b1;
                    state_d   = PW_IDLE;
                end else if (stop_i) begin
                    if (any_valid && !wp_i) begin
                        tmr_load = 1'b1;
                        state_d  = PW_PROGRAM;
                    end else begin
                        latch_clr = 1'b1;
                        state_d   = PW_IDLE;
                    end
                end else if (wdata_vld_i) begin
                    latch_wr = 1'b1;
                end
            end
            PW_PROGRAM: begin
                if (tmr_done) begin
                    latch_clr = 1'b1;
                    state_d   = PW_IDLE;
                end
            end
            default: state_d = PW_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PW_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q  <= '0;
            base_q <= '0;
            scan_q <= {1'b1, {OFF_W{1'b0}}};
        end else begin
            if (addr_load) begin
                base_q <= byte_i[ADDR_W-1:OFF_W];
                off_q  <= byte_i[OFF_W-1:0];
            end else if (latch_clr) begin
                off_q  <= '0;
            end else if (latch_wr) begin
                off_q  <= off_q + OFF_W'(1);
            end
            if (tmr_load) begin
                scan_q <= '0;
            end else if (state_q == PW_PROGRAM && !scan_q[OFF_W]) begin
                scan_q <= scan_q + SCAN_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        busy_o     = (state_q == PW_PROGRAM);
        arr_we_o   = busy_o && !scan_q[OFF_W] && rd_valid;
        arr_addr_o = {base_q, scan_q[OFF_W-1:0]};
        arr_data_o = rd_data;
    end

    // R5: busy only rises right after a STOP
    p_busy_after_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(stop_i));

    // R5: busy only falls when the timer expires
    p_busy_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(tmr_done));

    // R1: the page base stays fixed across one commit window
    p_page_fixed_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(arr_addr_o[ADDR_W-1:OFF_W]));

    // R4: successive writes climb in offset
    p_ascend_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we_o && $past(arr_we_o))
            |-> arr_addr_o[OFF_W-1:0] > $past(arr_addr_o[OFF_W-1:0]));

    // R6: a protected STOP starts no commit
    p_wp_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PW_COLLECT && stop_i && wp_i) |=> (!busy_o && !arr_we_o));

    // R7: a STOP with an empty latch starts no commit
    p_empty_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PW_COLLECT && stop_i && !any_valid) |=> !busy_o);
endmodule

// File: tb/page_write_buffer_tb_top.sv
`timescale 1ns/1ps
module page_write_buffer_tb_top;
    localparam int WR = 16;

    logic clk = 1'b0;
    logic rst_n, start_i, stop_i, waddr_vld_i, wdata_vld_i, wp_i;
    logic [7:0] byte_i;
    logic busy_o, arr_we_o;
    logic [7:0] arr_addr_o, arr_data_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    int         wr_cnt [256];
    logic [7:0] wr_val [256];
    logic [7:0] expd [8];
    bit         expv [8];

    always #10 clk = ~clk;

    page_write_buffer #(
        .ADDR_W(8), .DATA_W(8), .PAGE_ENTRIES(8), .WR_CYCLES(WR)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .waddr_vld_i(waddr_vld_i), .wdata_vld_i(wdata_vld_i), .byte_i(byte_i),
        .wp_i(wp_i), .busy_o(busy_o), .arr_we_o(arr_we_o),
        .arr_addr_o(arr_addr_o), .arr_data_o(arr_data_o)
    );

    // write monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n && arr_we_o) begin
            wr_cnt[arr_addr_o] = wr_cnt[arr_addr_o] + 1;
            wr_val[arr_addr_o] = arr_data_o;
            checks++;
            if (!busy_o) begin
                fails++;
                $display("FAIL R3 write outside busy: actual busy=%0d expected=1", busy_o);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_log();
        for (int a = 0; a < 256; a++) begin
            wr_cnt[a] = 0;
            wr_val[a] = 8'h00;
        end
        for (int i = 0; i < 8; i++) begin
            expv[i] = 1'b0;
            expd[i] = 8'h00;
        end
    endtask

    function automatic int total_writes();
        int s = 0;
        for (int a = 0; a < 256; a++) s += wr_cnt[a];
        return s;
    endfunction

    task automatic do_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic do_addr(input logic [7:0] b);
        @(negedge clk); byte_i = b; waddr_vld_i = 1'b1;
        @(negedge clk); waddr_vld_i = 1'b0;
    endtask

    task automatic do_data(input logic [7:0] b);
        @(negedge clk); byte_i = b; wdata_vld_i = 1'b1;
        @(negedge clk); wdata_vld_i = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk); stop_i = 1'b1;
        @(negedge clk); stop_i = 1'b0;
    endtask

    // counts busy cycles starting at the negedge right after the STOP edge
    task automatic busy_len(output int n);
        n = 0;
        while (busy_o && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic verify_page(input logic [4:0] base, input string req);
        int bad = 0;
        for (int a = 0; a < 256; a++) begin
            int expc;
            logic [7:0] av;
            av = a[7:0];
            expc = (av[7:3] == base && expv[av[2:0]]) ? 1 : 0;
            if (wr_cnt[a] != expc) bad++;
            else if (expc == 1 && wr_val[a] != expd[av[2:0]]) bad++;
        end
        chk(bad == 0, req, bad, 0);
    endtask

    initial begin
        #(4000000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        rst_n = 1'b0; start_i = 0; stop_i = 0; waddr_vld_i = 0; wdata_vld_i = 0;
        wp_i = 0; byte_i = 8'h00;
        clear_log();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy_o == 1'b0, "R10 busy after reset", busy_o, 0);
        chk(arr_we_o == 1'b0, "R10 write after reset", arr_we_o, 0);

        // sweep every start offset against one to ten bytes
        for (int o = 0; o < 8; o++) begin
            for (int nb = 1; nb <= 10; nb++) begin
                logic [4:0] base;
                logic [7:0] wa;
                string tag;
                base = 5'((o * 5 + nb * 3) % 32);
                wa   = {base, 3'(o)};
                clear_log();
                do_start();
                do_addr(wa);
                for (int k = 0; k < nb; k++) begin
                    logic [7:0] d;
                    d = 8'((int'(wa) * 7 + k * 29 + nb * 3) & 255);
                    expd[(o + k) % 8] = d;
                    expv[(o + k) % 8] = 1'b1;
                    do_data(d);
                end
                chk(total_writes() == 0, "R3 no write before STOP", total_writes(), 0);
                do_stop();
                busy_len(n);
                chk(n == WR, "R5 busy length", n, WR);
                tag = (nb > 8) ? "R2 wrap overwrite" : ((nb == 1) ? "R4 single byte" : "R1 page placement");
                verify_page(base, tag);
            end
        end

        // R6: write protect discards the page
        clear_log();
        wp_i = 1'b1;
        do_start(); do_addr(8'h2D);
        do_data(8'h11); do_data(8'h22); do_data(8'h33);
        do_stop();
        chk(busy_o == 1'b0, "R6 busy with protect", busy_o, 0);
        repeat (20) @(negedge clk);
        chk(total_writes() == 0, "R6 writes with protect", total_writes(), 0);
        wp_i = 1'b0;

        // R7: address only, then STOP
        clear_log();
        do_start(); do_addr(8'h77); do_stop();
        chk(busy_o == 1'b0, "R7 busy after empty STOP", busy_o, 0);
        repeat (20) @(negedge clk);
        chk(total_writes() == 0, "R7 writes after empty STOP", total_writes(), 0);

        // R8: repeated START drops earlier bytes
        clear_log();
        do_start(); do_addr(8'h10);
        do_data(8'hA1); do_data(8'hA2); do_data(8'hA3);
        do_start(); do_addr(8'hC5); do_data(8'h3C);
        expd[5] = 8'h3C; expv[5] = 1'b1;
        do_stop();
        busy_len(n);
        chk(n == WR, "R8 busy length", n, WR);
        verify_page(5'h18, "R8 restart clears");

        // R9: a full transaction during busy is ignored
        clear_log();
        do_start(); do_addr(8'h42);
        do_data(8'h5A); do_data(8'h5B);
        expd[2] = 8'h5A; expv[2] = 1'b1;
        expd[3] = 8'h5B; expv[3] = 1'b1;
        do_stop();
        do_start(); do_addr(8'h90); do_data(8'h55); do_stop();
        busy_len(n);
        n = 0;
        for (int c = 0; c < 30; c++) begin
            @(negedge clk);
            if (busy_o) n++;
        end
        chk(n == 0, "R9 no second busy", n, 0);
        verify_page(5'h08, "R9 events ignored while busy");

        finished = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule